// File: doc/BRIEF.md
# Raster Timing Generator with Frame-Period Trim

This block produces the synchronisation and data-enable signals for a parallel video output, together with the horizontal position and line index of the current pixel. Everything runs on the pixel clock. Each line has four parts in this order: a horizontal sync pulse, the back porch, the active pixels and the front porch. Each frame has the same four parts counted in lines: the vertical sync pulse, the back porch lines, the active lines and the front porch lines. The width of every part and the polarity of both sync signals are runtime settings.

The pixel clock can only be set in coarse steps, so a frame built from whole regular lines seldom lasts exactly the period the display expects. A target frame length, given in pixel clocks, fixes this. When the natural frame (line length times line count) is shorter than the target, the missing clocks are added to the front porch of the last line of the frame only. Every other line keeps its regular length and the active timing does not move. New settings are captured by a load strobe into a staging copy. They take effect at the next frame boundary, so no frame ever mixes two sets of settings.

Top module: `vtg_top`

## Requirements
- R1: After reset the generator uses HSYNC width 40 clocks, horizontal back and front porch 50 clocks each, VSYNC width 20 lines, vertical back porch 31 lines and vertical front porch 30 lines. Both syncs are active-high. Active size and target frame length come from the top parameters (defaults 1024x600 and 1019166 clocks, which is 61.15 MHz divided by 60). In the first cycle after reset, hsync and vsync are asserted, de is low, and pix_x and line_y are 0.
- R2: Each line starts with the horizontal sync asserted for exactly the programmed HSYNC width. The sync is asserted at positions 0 up to width-1 and is deasserted for the rest of the line.
- R3: de is high exactly at positions from sync+back porch up to sync+back porch+active-1, and only on active lines.
- R4: Every line except the last line of the frame lasts sync+back porch+active+front porch clocks.
- R5: A frame has sync+back porch+active+front porch lines. vsync is asserted on lines 0 up to VSYNC width-1. Active lines follow the vertical sync and back porch lines.
- R6: When the target exceeds the natural frame length, the last line is longer by the difference and the frame lasts exactly the target number of clocks.
- R7: When the target is at or below the natural frame length, no padding is added and the frame lasts its natural length.
- R8: A polarity bit of 1 makes its sync active-high and a polarity bit of 0 makes it active-low.
- R9: Values captured by cfg_load take effect only at the first clock of the next frame. The frame in progress keeps its old timing.
- R10: pix_x is the clock position within the current line and returns to 0 at each line start. line_y is the line index within the frame, counting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Capture all cfg_* inputs into the staging copy |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_h_sync | input | HW | HSYNC width in clocks |
| cfg_h_back | input | HW | Horizontal back porch in clocks |
| cfg_h_front | input | HW | Horizontal front porch in clocks |
| cfg_v_active | input | VW | Active lines per frame |
| cfg_v_sync | input | VW | VSYNC width in lines |
| cfg_v_back | input | VW | Vertical back porch in lines |
| cfg_v_front | input | VW | Vertical front porch in lines |
| cfg_hs_pol | input | 1 | HSYNC polarity, 1 = active-high |
| cfg_vs_pol | input | 1 | VSYNC polarity, 1 = active-high |
| cfg_frame_clks | input | FW | Target frame length in pixel clocks |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_x | output | FW | Clock position within the line |
| line_y | output | LW | Line index within the frame |

## Verification
The hardest case to reach from the ports is a settings change that arrives while a frame is in progress. The bench must show that the old timing holds up to the frame boundary and the new timing starts on the very next clock. It does this by pulsing cfg_load at the first clock of a frame and checking that frame against the old settings, cycle by cycle, before checking the next frame against the new ones. Padding is driven through three cases: more than a full line of padding, a target equal to the natural length, and a target below it. The sync polarity also flips at a frame boundary. To keep the reset frame short, the bench overrides the default active size and target, so the reset sync and porch values can be measured over a complete frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
    parameter int unsigned HW = 12;
    parameter int unsigned VW = 12;
    localparam int unsigned LW = VW + 2;
    localparam int unsigned FW = HW + VW + 4;

    typedef struct packed {
        logic [HW-1:0] h_act;
        logic [HW-1:0] h_sync;
        logic [HW-1:0] h_bp;
        logic [HW-1:0] h_fp;
        logic [VW-1:0] v_act;
        logic [VW-1:0] v_sync;
        logic [VW-1:0] v_bp;
        logic [VW-1:0] v_fp;
        logic          hs_pol;
        logic          vs_pol;
        logic [FW-1:0] target;
    } vtg_cfg_t;

    // clocks in one regular line
    function automatic logic [FW-1:0] line_clks(input vtg_cfg_t c);
        return FW'(c.h_sync) + FW'(c.h_bp) + FW'(c.h_act) + FW'(c.h_fp);
    endfunction

    // lines in one frame
    function automatic logic [LW-1:0] frame_lines(input vtg_cfg_t c);
        return LW'(c.v_sync) + LW'(c.v_bp) + LW'(c.v_act) + LW'(c.v_fp);
    endfunction

    function automatic logic [FW-1:0] natural_clks(input vtg_cfg_t c);
        return line_clks(c) * FW'(frame_lines(c));
    endfunction

    // extra clocks appended to the last line's front porch
    function automatic logic [FW-1:0] pad_clks(input vtg_cfg_t c);
        logic [FW-1:0] nat;
        nat = natural_clks(c);
        return (c.target > nat) ? (c.target - nat) : '0;
    endfunction
endpackage

// File: rtl/vtg_cfg_bank.sv
module vtg_cfg_bank
    import vtg_pkg::*;
#(
    parameter vtg_cfg_t DEF = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  vtg_cfg_t      cfg_in,
    input  logic          commit,
    output vtg_cfg_t      cur,
    output logic [FW-1:0] pad
);
    vtg_cfg_t staged;

    always_ff @(posedge clk) begin
        if (rst) begin
            staged <= DEF;
            cur    <= DEF;
            pad    <= pad_clks(DEF);
        end else begin
            if (load) begin
                staged <= cfg_in;
            end
            if (commit) begin
                cur <= staged;
                pad <= pad_clks(staged);
            end
        end
    end

    // settings in use only change at a frame boundary
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(cur));
    assert_pad_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(pad));
endmodule

// File: rtl/vtg_counter.sv
module vtg_counter
    import vtg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  vtg_cfg_t      cur,
    input  logic [FW-1:0] pad,
    output logic [FW-1:0] h_cnt,
    output logic [LW-1:0] v_cnt,
    output logic          frame_wrap
);
    logic [FW-1:0] h_tot;
    logic [LW-1:0] v_tot;
    logic [FW-1:0] h_len;
    logic          last_line;
    logic          line_end;

    always_comb begin
        h_tot      = line_clks(cur);
        v_tot      = frame_lines(cur);
        last_line  = (v_cnt == v_tot - LW'(1));
        h_len      = h_tot + (last_line ? pad : '0);
        line_end   = (h_cnt == h_len - FW'(1));
        frame_wrap = line_end && last_line;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_cnt <= '0;
            v_cnt <= '0;
        end else if (line_end) begin
            h_cnt <= '0;
            v_cnt <= last_line ? '0 : v_cnt + LW'(1);
        end else begin
            h_cnt <= h_cnt + FW'(1);
        end
    end

    // independent frame-length tally for the period check
    logic [FW:0] frm_cnt;
    logic [FW:0] frm_expect;
    always_ff @(posedge clk) begin
        if (rst || frame_wrap) frm_cnt <= '0;
        else                   frm_cnt <= frm_cnt + (FW+1)'(1);
    end
    always_comb begin
        frm_expect = (cur.target > natural_clks(cur)) ? (FW+1)'(cur.target)
                                                       : (FW+1)'(natural_clks(cur));
    end

    assert_hcnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        h_cnt < h_len);
    assert_vcnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        v_cnt < v_tot);
    assert_frame_len_R6: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |-> (frm_cnt + (FW+1)'(1) == frm_expect));
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
    import vtg_pkg::*;
(
    input  vtg_cfg_t      cur,
    input  logic [FW-1:0] h_cnt,
    input  logic [LW-1:0] v_cnt,
    output logic          hsync,
    output logic          vsync,
    output logic          de
);
    logic [FW-1:0] h_de_lo;
    logic [FW-1:0] h_de_hi;
    logic [LW-1:0] v_de_lo;
    logic [LW-1:0] v_de_hi;
    logic          hs_act;
    logic          vs_act;
    logic          de_h;
    logic          de_v;

    always_comb begin
        h_de_lo = FW'(cur.h_sync) + FW'(cur.h_bp);
        h_de_hi = h_de_lo + FW'(cur.h_act);
        v_de_lo = LW'(cur.v_sync) + LW'(cur.v_bp);
        v_de_hi = v_de_lo + LW'(cur.v_act);
        hs_act  = h_cnt < FW'(cur.h_sync);
        vs_act  = v_cnt < LW'(cur.v_sync);
        de_h    = (h_cnt >= h_de_lo) && (h_cnt < h_de_hi);
        de_v    = (v_cnt >= v_de_lo) && (v_cnt < v_de_hi);
        hsync   = cur.hs_pol ? hs_act : !hs_act;
        vsync   = cur.vs_pol ? vs_act : !vs_act;
        de      = de_h && de_v;
    end
endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned DEF_H_ACTIVE   = 1024,
    parameter int unsigned DEF_V_ACTIVE   = 600,
    parameter int unsigned DEF_FRAME_CLKS = 1019166
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_load,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [HW-1:0] cfg_h_sync,
    input  logic [HW-1:0] cfg_h_back,
    input  logic [HW-1:0] cfg_h_front,
    input  logic [VW-1:0] cfg_v_active,
    input  logic [VW-1:0] cfg_v_sync,
    input  logic [VW-1:0] cfg_v_back,
    input  logic [VW-1:0] cfg_v_front,
    input  logic          cfg_hs_pol,
    input  logic          cfg_vs_pol,
    input  logic [FW-1:0] cfg_frame_clks,
    output logic          hsync,
    output logic          vsync,
    output logic          de,
    output logic [FW-1:0] pix_x,
    output logic [LW-1:0] line_y
);
    localparam vtg_cfg_t DEF_CFG = '{
        h_act:  HW'(DEF_H_ACTIVE),
        h_sync: HW'(40),
        h_bp:   HW'(50),
        h_fp:   HW'(50),
        v_act:  VW'(DEF_V_ACTIVE),
        v_sync: VW'(20),
        v_bp:   VW'(31),
        v_fp:   VW'(30),
        hs_pol: 1'b1,
        vs_pol: 1'b1,
        target: FW'(DEF_FRAME_CLKS)
    };

    vtg_cfg_t      cfg_in;
    vtg_cfg_t      cur;
    logic [FW-1:0] pad;
    logic [FW-1:0] h_cnt;
    logic [LW-1:0] v_cnt;
    logic          frame_wrap;

    always_comb begin
        cfg_in.h_act  = cfg_h_active;
        cfg_in.h_sync = cfg_h_sync;
        cfg_in.h_bp   = cfg_h_back;
        cfg_in.h_fp   = cfg_h_front;
        cfg_in.v_act  = cfg_v_active;
        cfg_in.v_sync = cfg_v_sync;
        cfg_in.v_bp   = cfg_v_back;
        cfg_in.v_fp   = cfg_v_front;
        cfg_in.hs_pol = cfg_hs_pol;
        cfg_in.vs_pol = cfg_vs_pol;
        cfg_in.target = cfg_frame_clks;
    end

    vtg_cfg_bank #(.DEF(DEF_CFG)) i_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .cfg_in (cfg_in),
        .commit (frame_wrap),
        .cur    (cur),
        .pad    (pad)
    );

    vtg_counter i_cnt (
        .clk        (clk),
        .rst        (rst),
        .cur        (cur),
        .pad        (pad),
        .h_cnt      (h_cnt),
        .v_cnt      (v_cnt),
        .frame_wrap (frame_wrap)
    );

    vtg_decode i_dec (
        .cur   (cur),
        .h_cnt (h_cnt),
        .v_cnt (v_cnt),
        .hsync (hsync),
        .vsync (vsync),
        .de    (de)
    );

    assign pix_x  = h_cnt;
    assign line_y = v_cnt;
endmodule

// File: tb/test_vtg_top.sv
module test_vtg_top;
    import vtg_pkg::*;

    typedef struct {
        int ha, hs, hb, hf, va, vs, vb, vf, hp, vp, tg;
    } tcfg_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [HW-1:0] cfg_h_active = '0, cfg_h_sync = '0, cfg_h_back = '0, cfg_h_front = '0;
    logic [VW-1:0] cfg_v_active = '0, cfg_v_sync = '0, cfg_v_back = '0, cfg_v_front = '0;
    logic          cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0;
    logic [FW-1:0] cfg_frame_clks = '0;
    logic          hsync, vsync, de;
    logic [FW-1:0] pix_x;
    logic [LW-1:0] line_y;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    vtg_top #(.DEF_H_ACTIVE(16), .DEF_V_ACTIVE(4), .DEF_FRAME_CLKS(14000)) i_vtg_top (
        .clk(clk), .rst(rst), .cfg_load(cfg_load),
        .cfg_h_active(cfg_h_active), .cfg_h_sync(cfg_h_sync),
        .cfg_h_back(cfg_h_back), .cfg_h_front(cfg_h_front),
        .cfg_v_active(cfg_v_active), .cfg_v_sync(cfg_v_sync),
        .cfg_v_back(cfg_v_back), .cfg_v_front(cfg_v_front),
        .cfg_hs_pol(cfg_hs_pol), .cfg_vs_pol(cfg_vs_pol),
        .cfg_frame_clks(cfg_frame_clks),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive a new setting and pulse the load strobe for one clock
    task automatic load_cfg(input tcfg_t c);
        cfg_h_active = HW'(c.ha); cfg_h_sync = HW'(c.hs);
        cfg_h_back = HW'(c.hb);   cfg_h_front = HW'(c.hf);
        cfg_v_active = VW'(c.va); cfg_v_sync = VW'(c.vs);
        cfg_v_back = VW'(c.vb);   cfg_v_front = VW'(c.vf);
        cfg_hs_pol = c.hp[0];     cfg_vs_pol = c.vp[0];
        cfg_frame_clks = FW'(c.tg);
        cfg_load = 1'b1;
        fork
            begin @(negedge clk); cfg_load = 1'b0; end
        join_none
    endtask

    // observe one frame from its first clock; compare every cycle with c
    task automatic measure(input tcfg_t c, input string tag);
        int llen[0:255];
        int line = -1;
        int tot = 0;
        int e_hs = 0, e_vs = 0, e_de = 0, e_ly = 0;
        int htot = c.ha + c.hs + c.hb + c.hf;
        int vtot = c.va + c.vs + c.vb + c.vf;
        int nat  = htot * vtot;
        int pad  = (c.tg > nat) ? c.tg - nat : 0;
        int bad_len = 0, bad_val = 0;
        string pr;
        while (1) begin
            int  pos;
            bit  ehs, evs, ede;
            if (tot > 0 && pix_x == '0 && line_y == '0) break;
            if (tot > 30000) begin
                chk(0, {tag, " watchdog frame"}, tot, c.tg);
                break;
            end
            if (pix_x == '0 && line < 255) begin
                line++;
                llen[line] = 0;
            end
            pos = llen[line];
            ehs = pos < c.hs;
            evs = line < c.vs;
            ede = (line >= c.vs + c.vb) && (line < c.vs + c.vb + c.va) &&
                  (pos >= c.hs + c.hb) && (pos < c.hs + c.hb + c.ha);
            if (hsync !== (c.hp[0] ? ehs : !ehs)) e_hs++;
            if (vsync !== (c.vp[0] ? evs : !evs)) e_vs++;
            if (de !== ede) e_de++;
            if (int'(line_y) != line) e_ly++;
            llen[line]++;
            tot++;
            @(negedge clk);
        end
        for (int i = 0; i < line; i++) begin
            if (llen[i] != htot) begin bad_len++; bad_val = llen[i]; end
        end
        pr = (pad > 0) ? "R6" : "R7";
        chk(line + 1 == vtot, {tag, " R5 line count"}, line + 1, vtot);
        chk(bad_len == 0, {tag, " R4 regular line length"}, bad_val, htot);
        chk(line >= 0 && llen[line] == htot + pad, {tag, " ", pr, " last line length"},
            (line >= 0) ? llen[line] : -1, htot + pad);
        chk(tot == nat + pad, {tag, " ", pr, " frame period"}, tot, nat + pad);
        chk(e_hs == 0, {tag, " R2/R8 hsync mismatches"}, e_hs, 0);
        chk(e_vs == 0, {tag, " R5/R8 vsync mismatches"}, e_vs, 0);
        chk(e_de == 0, {tag, " R3 de mismatches"}, e_de, 0);
        chk(e_ly == 0, {tag, " R10 line_y mismatches"}, e_ly, 0);
    endtask

    localparam tcfg_t C_DEF = '{16, 40, 50, 50, 4, 20, 31, 30, 1, 1, 14000};
    localparam tcfg_t C_A   = '{16, 4, 3, 5, 6, 2, 2, 3, 1, 1, 400};
    localparam tcfg_t C_B   = '{16, 4, 3, 5, 6, 2, 2, 3, 1, 1, 364};
    localparam tcfg_t C_C   = '{10, 2, 1, 1, 3, 1, 1, 1, 0, 0, 200};
    localparam tcfg_t C_D   = '{10, 2, 1, 1, 3, 1, 1, 1, 1, 0, 50};

    task automatic t_reset_state;
        chk(hsync === 1'b1, "R1 hsync after reset", hsync, 1);
        chk(vsync === 1'b1, "R1 vsync after reset", vsync, 1);
        chk(de === 1'b0, "R1 de after reset", de, 0);
        chk(pix_x == '0, "R10 pix_x after reset", pix_x, 0);
        chk(line_y == '0, "R10 line_y after reset", line_y, 0);
    endtask

    task automatic t_default_frame;
        measure(C_DEF, "R1 default");
    endtask

    task automatic t_deferred_load;
        load_cfg(C_A);
        measure(C_DEF, "R9 pending");
    endtask

    task automatic t_padded_frame;
        load_cfg(C_B);
        measure(C_A, "R9 applied R6 padded");
    endtask

    task automatic t_exact_target;
        load_cfg(C_C);
        measure(C_B, "R7 exact");
    endtask

    task automatic t_low_polarity;
        load_cfg(C_D);
        measure(C_C, "R8 low pol R6 long pad");
    endtask

    task automatic t_short_target;
        measure(C_D, "R7 short R8 mixed");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state;
        t_default_frame;
        t_deferred_load;
        t_padded_frame;
        t_exact_target;
        t_low_polarity;
        t_short_target;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule